// File: doc/BRIEF.md
# Modem-Control Line Status Register

This block holds the two control/status registers of one asynchronous serial line: a receive-side register and a transmit-side register. A 16-bit host bus reaches them through word and byte accesses. Host accesses are decoded by a 2-bit select. Reads have side effects: reading the receive register returns an error summary and then clears the receive flags. Writes pass through fixed write masks. Byte writes merge into the current contents.

The block also handles the dataset handshake. Line events come in as single-cycle pulses: an incoming call, a loss of carrier, a received character and a finished transmission. A strap input selects whether modem control applies. Changes of the data-terminal-ready (DTR) bit, together with the ring and carrier state, answer or hang up the call and drive clear-to-send (CTS) in the transmit register. An event that raises carrier-change or error while interrupt-enable is set produces a one-cycle receive interrupt request for an external arbiter.

There is no data stream at the edge of this block. Every pin is a plain control or status signal with no valid/ready handshake. Host reads are combinational on the cycle `bus_rd` is high. Writes and read side effects take hold at the next rising clock edge.

Top module: `modem_line_csr`

## Requirements
- R1: After reset the receive register reads 0x0000, the transmit register reads 0x0080 (done set) and `rx_irq` is low.
- R2: `bus_sel` picks the register: 0 receive, 2 transmit, 1 and 3 read as zero. Receive bit positions are DTR 0, break 1, carrier-detect 2, parity 5, interrupt-enable 6, done 7, overrun 12, ring 13, carrier-change 14, error 15. Transmit bit positions are RTS 0, CTS 1, maintenance 2, interrupt-enable 6, done 7. Host writes reach only receive bits 0,1,3,4,6,8,9,10 (a write of 0xFFFF reads back 0x075B) and transmit bits 0,2,3,4,6,8 (0xFFFF reads back 0x01DD with done set).
- R3: A byte write (`bus_byte`=1) takes its data from `bus_wdata[7:0]`. With `bus_hi`=1 it replaces bits 15:8 and keeps bits 7:0. With `bus_hi`=0 it replaces bits 7:0 and keeps bits 15:8.
- R4: A receive-register read returns error as the OR of overrun, ring and carrier-change. From the next cycle, done, overrun, ring, carrier-change and error read as zero, and other bits are kept.
- R5: With modem control on, a DTR 0→1 write while ring is set clears ring, sets carrier-detect, carrier-change and error, and sets CTS.
- R6: With modem control on, a DTR 1→0 write clears carrier-detect, ring and CTS. If carrier-detect was set, it also sets carrier-change and error.
- R7: An incoming call with modem control on sets carrier-detect, carrier-change and error if DTR is set. If DTR is clear, it sets ring and error. With modem control off, the call sets only CTS.
- R8: Carrier loss clears carrier-detect, ring and CTS. If modem control is on and carrier-detect was set, it also sets carrier-change and error.
- R9: A received character sets done. If done is already set, it sets overrun instead.
- R10: A write with `bus_sel`=3 clears transmit done. `tx_sent` sets it again.
- R11: `rx_irq` pulses for one cycle, one clock after an event or write that sets carrier-change or error while interrupt-enable is set. It stays low otherwise.
- R12: A line event in the same cycle as a receive-register read is not lost. The read returns the old value, and the event's flags are visible afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_sel | input | 2 | Register select |
| bus_byte | input | 1 | Byte access when high |
| bus_hi | input | 1 | Byte access targets the high byte |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| modem_en | input | 1 | Modem-control strap |
| line_connect | input | 1 | Incoming-call pulse |
| line_carrier_lost | input | 1 | Carrier-loss pulse |
| rx_char | input | 1 | Character-received pulse |
| tx_sent | input | 1 | Transmission-finished pulse |
| rx_irq | output | 1 | Receive interrupt request pulse |

## Verification
A host read of the receive register clears its flags, and a line event in the same cycle sets flags. These two collide at one clock edge. The bench provokes this with an incoming call in the read cycle, and again with a received character in the read cycle. It judges the result by two things: the read must return the value from before the event, and the following read must show carrier-detect, carrier-change and error, or done. The same cycle-ordering rule decides overrun when a character lands on a read.

// File: rtl/mlc_pkg.sv
package mlc_pkg;
  localparam int CSR_W  = 16;
  localparam int BYTE_W = 8;

  localparam int RX_DTR  = 0;
  localparam int RX_CDT  = 2;
  localparam int RX_IE   = 6;
  localparam int RX_DONE = 7;
  localparam int RX_OVR  = 12;
  localparam int RX_RNG  = 13;
  localparam int RX_CCH  = 14;
  localparam int RX_ERR  = 15;

  localparam int TX_CTS  = 1;
  localparam int TX_DONE = 7;

  localparam logic [CSR_W-1:0] RX_RD_MASK = 16'o173777;
  localparam logic [CSR_W-1:0] RX_WR_MASK = 16'o003533;
  localparam logic [CSR_W-1:0] TX_RD_MASK = 16'o100737;
  localparam logic [CSR_W-1:0] TX_WR_MASK = 16'o000535;
  localparam logic [CSR_W-1:0] RX_RESET   = '0;
  localparam logic [CSR_W-1:0] TX_RESET   = 16'h0080;

  localparam logic [CSR_W-1:0] RX_CLR_ON_READ =
    (CSR_W'(1) << RX_DONE) | (CSR_W'(1) << RX_OVR) | (CSR_W'(1) << RX_RNG) |
    (CSR_W'(1) << RX_CCH)  | (CSR_W'(1) << RX_ERR);

  typedef enum logic [1:0] {
    SEL_RX_CSR = 2'd0,
    SEL_RX_BUF = 2'd1,
    SEL_TX_CSR = 2'd2,
    SEL_TX_BUF = 2'd3
  } reg_sel_e;

  function automatic logic [CSR_W-1:0] merge_write(
    input logic [CSR_W-1:0] cur,
    input logic [CSR_W-1:0] wd,
    input logic             byte_acc,
    input logic             hi_lane
  );
    logic [CSR_W-1:0] r;
    if (!byte_acc)    r = wd;
    else if (hi_lane) r = {wd[BYTE_W-1:0], cur[BYTE_W-1:0]};
    else              r = {cur[CSR_W-1:BYTE_W], wd[BYTE_W-1:0]};
    return r;
  endfunction
endpackage

// File: rtl/mlc_rx_csr.sv
module mlc_rx_csr
  import mlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             modem_en,
  input  logic             ev_connect,
  input  logic             ev_lost,
  input  logic             ev_char,
  output logic [CSR_W-1:0] csr_q,
  output logic [CSR_W-1:0] rd_view,
  output logic             cts_upd,
  output logic             cts_val,
  output logic             irq
);
  logic [CSR_W-1:0] nxt;
  logic             irq_now;
  logic             irq_q;

  always_comb begin
    logic [CSR_W-1:0] v;
    v = csr_q;
    v[RX_ERR] = csr_q[RX_OVR] | csr_q[RX_RNG] | csr_q[RX_CCH];
    rd_view = v & RX_RD_MASK;
  end

  always_comb begin
    nxt     = csr_q;
    irq_now = 1'b0;
    cts_upd = 1'b0;
    cts_val = 1'b0;
    // host write, including the dataset handshake on a DTR edge
    if (wr_en) begin
      if (modem_en && (wr_data[RX_DTR] != csr_q[RX_DTR])) begin
        if (wr_data[RX_DTR]) begin
          if (csr_q[RX_RNG]) begin
            nxt[RX_RNG] = 1'b0;
            nxt[RX_CDT] = 1'b1;
            nxt[RX_CCH] = 1'b1;
            nxt[RX_ERR] = 1'b1;
            cts_upd = 1'b1;
            cts_val = 1'b1;
            irq_now = irq_now | wr_data[RX_IE];
          end
        end else begin
          if (csr_q[RX_CDT]) begin
            nxt[RX_CCH] = 1'b1;
            nxt[RX_ERR] = 1'b1;
            irq_now = irq_now | wr_data[RX_IE];
          end
          nxt[RX_CDT] = 1'b0;
          nxt[RX_RNG] = 1'b0;
          cts_upd = 1'b1;
          cts_val = 1'b0;
        end
      end
      nxt = (nxt & ~RX_WR_MASK) | (wr_data & RX_WR_MASK);
    end
    // read side effect comes before line events so events survive
    if (rd_en) nxt = nxt & ~RX_CLR_ON_READ;
    if (ev_connect) begin
      if (modem_en) begin
        if (nxt[RX_DTR]) begin
          nxt[RX_CDT] = 1'b1;
          nxt[RX_CCH] = 1'b1;
        end else begin
          nxt[RX_RNG] = 1'b1;
        end
        nxt[RX_ERR] = 1'b1;
        irq_now = irq_now | nxt[RX_IE];
      end else begin
        cts_upd = 1'b1;
        cts_val = 1'b1;
      end
    end
    if (ev_lost) begin
      if (modem_en && nxt[RX_CDT]) begin
        nxt[RX_CCH] = 1'b1;
        nxt[RX_ERR] = 1'b1;
        irq_now = irq_now | nxt[RX_IE];
      end
      nxt[RX_CDT] = 1'b0;
      nxt[RX_RNG] = 1'b0;
      cts_upd = 1'b1;
      cts_val = 1'b0;
    end
    if (ev_char) begin
      if (nxt[RX_DONE]) nxt[RX_OVR]  = 1'b1;
      else              nxt[RX_DONE] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_q <= RX_RESET;
      irq_q <= 1'b0;
    end else begin
      csr_q <= nxt;
      irq_q <= irq_now;
    end
  end

  assign irq = irq_q;

  AST_CCH_BRINGS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_q[RX_CCH]) |-> csr_q[RX_ERR]); // R8
  AST_CDT_NEEDS_MODEM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csr_q[RX_CDT]) |-> $past(modem_en)); // R7
  AST_READ_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && !ev_connect && !ev_lost && !ev_char)
      |=> ((csr_q & RX_CLR_ON_READ) == '0)); // R4
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(wr_en) && !$past(ev_connect) && !$past(ev_lost)) |-> 1'b0); // R11
endmodule

// File: rtl/mlc_tx_csr.sv
module mlc_tx_csr
  import mlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic             buf_wr,
  input  logic             tx_sent,
  input  logic             cts_upd,
  input  logic             cts_val,
  output logic [CSR_W-1:0] csr_q
);
  logic [CSR_W-1:0] nxt;

  always_comb begin
    nxt = csr_q;
    if (wr_en)   nxt = (nxt & ~TX_WR_MASK) | (wr_data & TX_WR_MASK);
    if (buf_wr)  nxt[TX_DONE] = 1'b0;
    if (tx_sent) nxt[TX_DONE] = 1'b1;
    if (cts_upd) nxt[TX_CTS]  = cts_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) csr_q <= TX_RESET;
    else        csr_q <= nxt;
  end

  AST_CTS_TRACKS_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    cts_upd |=> (csr_q[TX_CTS] == $past(cts_val))); // R5
  AST_BUF_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && !tx_sent) |=> !csr_q[TX_DONE]); // R10
endmodule

// File: rtl/modem_line_csr.sv
module modem_line_csr
  import mlc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [1:0]       bus_sel,
  input  logic             bus_byte,
  input  logic             bus_hi,
  input  logic [CSR_W-1:0] bus_wdata,
  output logic [CSR_W-1:0] bus_rdata,
  input  logic             modem_en,
  input  logic             line_connect,
  input  logic             line_carrier_lost,
  input  logic             rx_char,
  input  logic             tx_sent,
  output logic             rx_irq
);
  logic [CSR_W-1:0] rx_q, rx_view, tx_q, rx_wd, tx_wd;
  logic             cts_upd, cts_val;
  logic             rx_rd, rx_wr, tx_wr, tx_buf_wr;

  assign rx_rd     = bus_rd && (bus_sel == SEL_RX_CSR);
  assign rx_wr     = bus_wr && (bus_sel == SEL_RX_CSR);
  assign tx_wr     = bus_wr && (bus_sel == SEL_TX_CSR);
  assign tx_buf_wr = bus_wr && (bus_sel == SEL_TX_BUF);
  assign rx_wd     = merge_write(rx_q, bus_wdata, bus_byte, bus_hi);
  assign tx_wd     = merge_write(tx_q, bus_wdata, bus_byte, bus_hi);

  mlc_rx_csr u_rx (
    .clk(clk), .rst_n(rst_n), .rd_en(rx_rd), .wr_en(rx_wr), .wr_data(rx_wd),
    .modem_en(modem_en), .ev_connect(line_connect), .ev_lost(line_carrier_lost),
    .ev_char(rx_char), .csr_q(rx_q), .rd_view(rx_view),
    .cts_upd(cts_upd), .cts_val(cts_val), .irq(rx_irq)
  );

  mlc_tx_csr u_tx (
    .clk(clk), .rst_n(rst_n), .wr_en(tx_wr), .wr_data(tx_wd),
    .buf_wr(tx_buf_wr), .tx_sent(tx_sent),
    .cts_upd(cts_upd), .cts_val(cts_val), .csr_q(tx_q)
  );

  always_comb begin
    case (bus_sel)
      SEL_RX_CSR: bus_rdata = rx_view;
      SEL_TX_CSR: bus_rdata = tx_q & TX_RD_MASK;
      default:    bus_rdata = '0;
    endcase
  end

  AST_HOST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr)); // R2
  AST_MODEM_OFF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq && !$past(bus_wr)) |-> $past(modem_en)); // R11
endmodule

// File: tb/modem_line_csr_tb.sv
`timescale 1ns/1ps
module modem_line_csr_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_rd = 0, bus_wr = 0, bus_byte = 0, bus_hi = 0;
  logic [1:0]  bus_sel = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        modem_en = 0, line_connect = 0, line_carrier_lost = 0;
  logic        rx_char = 0, tx_sent = 0;
  logic        rx_irq;
  int          checks = 0, failures = 0;
  bit          finished = 0;
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #4 clk = ~clk;

  modem_line_csr u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_sel(bus_sel), .bus_byte(bus_byte), .bus_hi(bus_hi),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .modem_en(modem_en),
    .line_connect(line_connect), .line_carrier_lost(line_carrier_lost),
    .rx_char(rx_char), .tx_sent(tx_sent), .rx_irq(rx_irq)
  );

  // monitor: compares each read against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && bus_rd) begin
      checks++;
      if (q_exp.size() == 0) begin
        failures++;
        $display("FAIL unexpected read actual=%h expected=none", bus_rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        if (bus_rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic cyc(input logic rd, input logic wr, input logic [1:0] sel,
                     input logic bt, input logic hi, input logic [15:0] wd,
                     input logic cn, input logic ls, input logic ch,
                     input logic sn, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    if (rd) begin q_exp.push_back(exp); q_tag.push_back(tag); end
    bus_rd = rd; bus_wr = wr; bus_sel = sel; bus_byte = bt; bus_hi = hi;
    bus_wdata = wd; line_connect = cn; line_carrier_lost = ls;
    rx_char = ch; tx_sent = sn;
    @(posedge clk); #1;
    bus_rd = 0; bus_wr = 0; bus_byte = 0; bus_hi = 0;
    line_connect = 0; line_carrier_lost = 0; rx_char = 0; tx_sent = 0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
    cyc(1, 0, sel, 0, 0, 16'h0, 0, 0, 0, 0, exp, tag);
  endtask
  task automatic wrw(input logic [1:0] sel, input logic [15:0] d);
    cyc(0, 1, sel, 0, 0, d, 0, 0, 0, 0, 16'h0, "");
  endtask
  task automatic wrb(input logic hi, input logic [15:0] d);
    cyc(0, 1, 2'd0, 1, hi, d, 0, 0, 0, 0, 16'h0, "");
  endtask
  task automatic ev(input logic cn, input logic ls, input logic ch, input logic sn);
    cyc(0, 0, 2'd0, 0, 0, 16'h0, cn, ls, ch, sn, 16'h0, "");
  endtask
  task automatic chk_irq(input logic exp, input string tag);
    checks++;
    if (rx_irq !== exp) begin
      failures++;
      $display("FAIL %s irq actual=%b expected=%b", tag, rx_irq, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset values
    rd(0, 16'h0000, "R1 rx reset");
    rd(2, 16'h0080, "R1 tx reset");
    chk_irq(0, "R1");
    // R2 decode and masks
    rd(1, 16'h0000, "R2 sel1 zero");
    rd(3, 16'h0000, "R2 sel3 zero");
    wrw(0, 16'hFFFF);
    rd(0, 16'h075B, "R2 rx write mask");
    wrw(0, 16'h0000);
    rd(0, 16'h0000, "R2 rx cleared");
    wrw(2, 16'hFFFF);
    rd(2, 16'h01DD, "R2 tx write mask");
    wrw(2, 16'h0000);
    rd(2, 16'h0080, "R2 tx cleared");
    // R3 byte lanes
    wrb(1, 16'h0007);
    wrb(0, 16'h0048);
    rd(0, 16'h0748, "R3 byte merge");
    wrw(0, 16'h0000);
    // modem on: ring, answer
    modem_en = 1;
    wrw(0, 16'h0040);
    ev(1, 0, 0, 0);
    chk_irq(1, "R11 ring irq");
    rd(0, 16'hA040, "R7 ring no dtr");
    rd(0, 16'h0040, "R4 read clears");
    ev(1, 0, 0, 0);
    wrw(0, 16'h0041);
    chk_irq(1, "R5 answer irq");
    rd(2, 16'h0082, "R5 cts set");
    rd(0, 16'hC045, "R5 answer flags");
    rd(0, 16'h0045, "R4 cdt kept");
    // R6 hangup
    wrw(0, 16'h0040);
    chk_irq(1, "R6 hangup irq");
    rd(0, 16'hC040, "R6 hangup flags");
    rd(2, 16'h0080, "R6 cts cleared");
    // R7 call with dtr, R8 carrier loss
    wrw(0, 16'h0041);
    chk_irq(0, "R11 no ring no irq");
    rd(0, 16'h0041, "R5 rise without ring");
    ev(1, 0, 0, 0);
    chk_irq(1, "R7 call irq");
    rd(0, 16'hC045, "R7 call with dtr");
    ev(0, 1, 0, 0);
    rd(0, 16'hC041, "R8 carrier lost");
    rd(2, 16'h0080, "R8 tx after loss");
    // modem off
    modem_en = 0;
    ev(1, 0, 0, 0);
    rd(2, 16'h0082, "R7 cts only");
    rd(0, 16'h0041, "R7 rx untouched");
    ev(0, 1, 0, 0);
    chk_irq(0, "R8 no irq modem off");
    rd(2, 16'h0080, "R8 cts clear modem off");
    rd(0, 16'h0041, "R8 rx untouched");
    // R9 characters
    ev(0, 0, 1, 0);
    rd(0, 16'h00C1, "R9 done");
    rd(0, 16'h0041, "R9 done cleared");
    ev(0, 0, 1, 0);
    ev(0, 0, 1, 0);
    rd(0, 16'h90C1, "R9 overrun");
    rd(0, 16'h0041, "R9 overrun cleared");
    // R10 transmit done
    wrw(3, 16'h0055);
    rd(2, 16'h0000, "R10 buf write clears done");
    ev(0, 0, 0, 1);
    rd(2, 16'h0080, "R10 sent sets done");
    // R12 same-cycle read and event
    modem_en = 1;
    cyc(1, 0, 0, 0, 0, 16'h0, 1, 0, 0, 0, 16'h0041, "R12 read old value");
    rd(0, 16'hC045, "R12 call survives read");
    cyc(1, 0, 0, 0, 0, 16'h0, 0, 0, 1, 0, 16'h0045, "R12 read before char");
    rd(0, 16'h00C5, "R12 char survives read");
    // R11 no irq with ie clear
    wrw(0, 16'h0001);
    ev(0, 1, 0, 0);
    chk_irq(0, "R11 ie clear");
    rd(0, 16'hC001, "R8 loss with ie clear");
    repeat (2) @(posedge clk);
    if (q_exp.size() != 0) begin
      checks++; failures++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", q_exp.size());
    end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule